// File: doc/BRIEF.md
# Long Multiply-Accumulate Unit

This block executes the multiply class of a 32-bit processor's data-processing instructions. It takes the instruction word together with up to four register values already read from the register file, and after a fixed number of cycles hands back one or two 32-bit register writes plus the negative and zero condition flags. It covers the plain 32-bit multiply, the 32-bit multiply with an added third operand, and the 64-bit long multiply in signed or unsigned form, optionally accumulating into a 64-bit value held in a register pair.

The caller raises `start` for one cycle with the instruction and operands. The unit latches everything it needs on that edge, then runs a shift-and-add loop of one multiplier bit per cycle. When the loop finishes, `done` pulses for one cycle, and in that same cycle the write ports and flag outputs are valid. The carry and overflow flags are never touched: only the negative and zero flags are offered, under a write enable.

Operand naming: `opnd_m` and `opnd_s` are the two factors. `opnd_a` is the value of the register named by instruction bits 19:16, and `opnd_b` is the value of the register named by bits 15:12.

Top module: `lmac_unit`

## Requirements
- R1: A `start` whose instruction does not carry the pattern 1001 in bits 7:4 is not accepted: `busy` stays low and no `done` follows.
- R2: An accepted `start` (bits 7:4 equal 1001, unit idle) makes `busy` high from the next cycle. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R3: `done` rises exactly 32 clock edges after the accepting edge. A `start` raised while `busy` is high is ignored and does not change the result or the timing of the operation in flight.
- R4: With bit 23 clear and bit 21 clear, port A writes the low 32 bits of `opnd_m*opnd_s` to the register index in bits 19:16, and port B does not write.
- R5: With bit 23 clear and bit 21 set, port A writes the low 32 bits of `opnd_m*opnd_s + opnd_b`. Bit 22 has no effect on the short forms.
- R6: With bit 23 set and bit 22 clear, the unsigned 64-bit product is split: port A writes the high word to the index in bits 19:16, and port B writes the low word to the index in bits 15:12.
- R7: With bits 23 and 22 set, both factors are sign-extended to 64 bits before multiplying, and the 64-bit result is split as in R6.
- R8: With bits 23 and 21 set, the 64-bit value {`opnd_a`,`opnd_b`} is added to the product before the split.
- R9: With bit 20 set, `flag_we` is high with `done`. `flag_n` equals bit 31 of the low result word, and `flag_z` is high exactly when the low word is zero, for long forms too. With bit 20 clear, `flag_we` stays low.
- R10: Under reset and outside the `done` cycle, `busy` (reset only), `done`, `wa_en`, `wb_en` and `flag_we` are all low.
- R11: Operands and instruction are captured at the accepting edge. Changing them while `busy` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| instr | input | 32 | Multiply-class instruction word |
| opnd_m | input | 32 | First factor |
| opnd_s | input | 32 | Second factor |
| opnd_a | input | 32 | Value of register at bits 19:16 (high addend for long accumulate) |
| opnd_b | input | 32 | Value of register at bits 15:12 (short addend, low addend for long accumulate) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wa_en | output | 1 | Write enable, port A |
| wa_idx | output | 4 | Register index, port A |
| wa_data | output | 32 | Write data, port A (short result or high word) |
| wb_en | output | 1 | Write enable, port B (long forms only) |
| wb_idx | output | 4 | Register index, port B |
| wb_data | output | 32 | Write data, port B (low word) |
| flag_we | output | 1 | Flag update enable |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |

## Verification
The assertions check the handshake on every cycle: acceptance or rejection of a request, the single-cycle `done` with `busy` released, the 32-edge latency counted from the accepting edge, the write enables being silent outside `done`, and the consistency of the zero and negative flags with whichever write port carries the low word. Only the bench scenarios can show that the arithmetic is right. That covers signed correction at extreme factors, 64-bit accumulate with carry from the low into the high word, and a zero low word under a non-zero high word. It also covers the result staying tied to the operands seen at acceptance, even when a second request or changed operands arrive while the loop runs.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

    // Bits 7:4 of every multiply-class instruction
    localparam logic [3:0] MUL_SIG = 4'b1001;

    typedef struct packed {
        logic       valid;      // pattern matched
        logic       is_long;    // 64-bit result
        logic       is_signed;  // signed factors (long forms only)
        logic       accum;      // add an addend
        logic       set_flags;  // update N and Z
        logic [3:0] idx_a;      // bits 19:16
        logic [3:0] idx_b;      // bits 15:12
    } mul_dec_t;

endpackage

// File: rtl/lmac_decode.sv
module lmac_decode
    import lmac_pkg::*;
(
    input  logic [31:0] instr,
    output mul_dec_t    dec
);

    always_comb begin
        dec.valid     = (instr[7:4] == MUL_SIG);
        dec.is_long   = instr[23];
        dec.is_signed = instr[23] & instr[22];
        dec.accum     = instr[21];
        dec.set_flags = instr[20];
        dec.idx_a     = instr[19:16];
        dec.idx_b     = instr[15:12];
    end

endmodule

// File: rtl/lmac_seed.sv
// Initial accumulator value: addend minus the two's-complement correction
// terms that turn an unsigned shift-add product into a signed one.
module lmac_seed
    import lmac_pkg::*;
#(
    parameter int W = 32
) (
    input  mul_dec_t         dec,
    input  logic [W-1:0]     opnd_m,
    input  logic [W-1:0]     opnd_s,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic [2*W-1:0]   seed
);

    localparam int DW = 2 * W;

    logic [DW-1:0] addend;
    logic [DW-1:0] corr_m;
    logic [DW-1:0] corr_s;

    always_comb begin
        if (!dec.accum)
            addend = '0;
        else if (dec.is_long)
            addend = {opnd_a, opnd_b};
        else
            addend = {{W{1'b0}}, opnd_b};

        corr_m = (dec.is_signed && opnd_m[W-1]) ? {opnd_s, {W{1'b0}}} : '0;
        corr_s = (dec.is_signed && opnd_s[W-1]) ? {opnd_m, {W{1'b0}}} : '0;
        seed   = addend - corr_m - corr_s;
    end

endmodule

// File: rtl/lmac_step.sv
// One shift-and-add iteration: consumes the low multiplier bit.
module lmac_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc,
    input  logic [2*W-1:0] mcand,
    input  logic [W-1:0]   mplier,
    output logic [2*W-1:0] acc_nx,
    output logic [2*W-1:0] mcand_nx,
    output logic [W-1:0]   mplier_nx
);

    always_comb begin
        acc_nx    = mplier[0] ? (acc + mcand) : acc;
        mcand_nx  = mcand << 1;
        mplier_nx = mplier >> 1;
    end

endmodule

// File: rtl/lmac_unit.sv
module lmac_unit
    import lmac_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [31:0]  instr,
    input  logic [W-1:0] opnd_m,
    input  logic [W-1:0] opnd_s,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic         busy,
    output logic         done,
    output logic         wa_en,
    output logic [3:0]   wa_idx,
    output logic [W-1:0] wa_data,
    output logic         wb_en,
    output logic [3:0]   wb_idx,
    output logic [W-1:0] wb_data,
    output logic         flag_we,
    output logic         flag_n,
    output logic         flag_z
);

    localparam int            DW   = 2 * W;
    localparam int            CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic          is_long;
        logic          set_flags;
        logic [3:0]    idx_a;
        logic [3:0]    idx_b;
        logic [DW-1:0] acc;
        logic [DW-1:0] mcand;
        logic [W-1:0]  mplier;
    } lmac_st_t;

    lmac_st_t st_q, st_d;
    mul_dec_t dec;
    logic [DW-1:0] seed;
    logic [DW-1:0] acc_nx, mcand_nx;
    logic [W-1:0]  mplier_nx;
    logic          accept;

    lmac_decode u_decode (
        .instr (instr),
        .dec   (dec)
    );

    lmac_seed #(.W(W)) u_seed (
        .dec    (dec),
        .opnd_m (opnd_m),
        .opnd_s (opnd_s),
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .seed   (seed)
    );

    lmac_step #(.W(W)) u_step (
        .acc       (st_q.acc),
        .mcand     (st_q.mcand),
        .mplier    (st_q.mplier),
        .acc_nx    (acc_nx),
        .mcand_nx  (mcand_nx),
        .mplier_nx (mplier_nx)
    );

    assign accept = start & ~st_q.busy & dec.valid;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            st_d.acc    = acc_nx;
            st_d.mcand  = mcand_nx;
            st_d.mplier = mplier_nx;
            st_d.cnt    = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end else if (accept) begin
            st_d.busy      = 1'b1;
            st_d.cnt       = '0;
            st_d.is_long   = dec.is_long;
            st_d.set_flags = dec.set_flags;
            st_d.idx_a     = dec.idx_a;
            st_d.idx_b     = dec.idx_b;
            st_d.acc       = seed;
            st_d.mcand     = {{W{1'b0}}, opnd_m};
            st_d.mplier    = opnd_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    logic [W-1:0] low_word;
    assign low_word = st_q.acc[W-1:0];

    assign busy    = st_q.busy;
    assign done    = st_q.done;
    assign wa_en   = st_q.done;
    assign wa_idx  = st_q.idx_a;
    assign wa_data = st_q.is_long ? st_q.acc[DW-1:W] : low_word;
    assign wb_en   = st_q.done & st_q.is_long;
    assign wb_idx  = st_q.idx_b;
    assign wb_data = low_word;
    assign flag_we = st_q.done & st_q.set_flags;
    assign flag_n  = flag_we & low_word[W-1];
    assign flag_z  = flag_we & (low_word == '0);

endmodule

// File: rtl/lmac_chk.sv
module lmac_chk
    import lmac_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [31:0]  instr,
    input logic         busy,
    input logic         done,
    input logic         wa_en,
    input logic [W-1:0] wa_data,
    input logic         wb_en,
    input logic [W-1:0] wb_data,
    input logic         flag_we,
    input logic         flag_n,
    input logic         flag_z
);

    localparam int SW = $clog2(W) + 2;

    logic          take;
    logic [SW-1:0] span;

    assign take = start && !busy && (instr[7:4] == MUL_SIG);

    always_ff @(posedge clk) begin
        if (!rst_n)
            span <= '0;
        else if (take)
            span <= '0;
        else if (busy)
            span <= span + 1'b1;
    end

    // R1
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && instr[7:4] != MUL_SIG) |=> !busy);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (span == SW'(W)));

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(wa_en || wb_en || flag_we));

    // R9
    zlong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && wb_en) |-> (flag_z == (wb_data == '0)) && (flag_n == wb_data[W-1]));

    // R9
    zshort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !wb_en) |-> (flag_z == (wa_data == '0)) && (flag_n == wa_data[W-1]));

endmodule

bind lmac_unit lmac_chk #(.W(W)) u_lmac_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .instr   (instr),
    .busy    (busy),
    .done    (done),
    .wa_en   (wa_en),
    .wa_data (wa_data),
    .wb_en   (wb_en),
    .wb_data (wb_data),
    .flag_we (flag_we),
    .flag_n  (flag_n),
    .flag_z  (flag_z)
);

// File: tb/test_lmac_unit.sv
module test_lmac_unit;

    localparam int  W          = 32;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] om = '0, os = '0, oa = '0, ob = '0;
    logic        busy, done, wa_en, wb_en, flag_we, flag_n, flag_z;
    logic [3:0]  wa_idx, wb_idx;
    logic [31:0] wa_data, wb_data;

    lmac_unit #(.W(W)) i_lmac_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .opnd_m(om), .opnd_s(os), .opnd_a(oa), .opnd_b(ob),
        .busy(busy), .done(done),
        .wa_en(wa_en), .wa_idx(wa_idx), .wa_data(wa_data),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .flag_we(flag_we), .flag_n(flag_n), .flag_z(flag_z)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_tag = "R10";

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit lng, input bit sgn, input bit acc,
                                       input bit sf, input logic [3:0] ia,
                                       input logic [3:0] ib);
        return {8'h00, lng, sgn, acc, sf, ia, ib, 4'h3, 4'b1001, 4'h2};
    endfunction

    // ---------------- behavioural reference model ----------------
    bit          m_busy = 0, m_done = 0, m_long = 0, m_setf = 0, was_busy = 0;
    int          m_left = 0;
    logic [63:0] m_res = '0, xm, xs, add;
    logic [3:0]  m_ia = '0, m_ib = '0;
    string       m_tag = "R10";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_left = 0;
        end else begin
            was_busy = m_busy;
            m_done = 0;
            if (was_busy) begin
                m_left--;
                if (m_left == 0) begin m_busy = 0; m_done = 1; end
            end else if (start && instr[7:4] == 4'b1001) begin
                xm  = (instr[23] && instr[22]) ? {{32{om[31]}}, om} : {32'h0, om};
                xs  = (instr[23] && instr[22]) ? {{32{os[31]}}, os} : {32'h0, os};
                add = !instr[21] ? 64'h0 : (instr[23] ? {oa, ob} : {32'h0, ob});
                m_res  = xm * xs + add;
                m_long = instr[23];
                m_setf = instr[20];
                m_ia   = instr[19:16];
                m_ib   = instr[15:12];
                m_tag  = cur_tag;
                m_busy = 1;
                m_left = 32;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    logic [31:0] exp_a;
    always @(negedge clk) begin
        if (rst_n) begin
            chk({busy, done} == {m_busy, m_done}, "R2", "busy/done",
                {62'h0, busy, done}, {62'h0, m_busy, m_done});
            if (m_done) begin
                exp_a = m_long ? m_res[63:32] : m_res[31:0];
                chk(wa_en && wa_idx == m_ia && wa_data == exp_a, m_tag, "port A",
                    {wa_en, wa_idx, wa_data}, {1'b1, m_ia, exp_a});
                chk(wb_en == m_long && (!m_long || (wb_idx == m_ib && wb_data == m_res[31:0])),
                    m_tag, "port B", {wb_en, wb_idx, wb_data},
                    {m_long, m_ib, m_res[31:0]});
                chk(flag_we == m_setf &&
                    (!m_setf || (flag_n == m_res[31] && flag_z == (m_res[31:0] == 32'h0))),
                    "R9", "flags", {flag_we, flag_n, flag_z},
                    {m_setf, m_res[31], m_res[31:0] == 32'h0});
            end else begin
                chk(!wa_en && !wb_en && !flag_we, "R10", "idle enables",
                    {wa_en, wb_en, flag_we}, 3'b000);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_done(input string tag);
        int k = 0;
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(done, tag, "done seen", {63'h0, done}, 64'h1);
        @(negedge clk);
    endtask

    // poke > 0 raises a second start that many cycles into the run (R3)
    task automatic run_op(input logic [31:0] ins, input logic [31:0] m, input logic [31:0] s,
                          input logic [31:0] a, input logic [31:0] b,
                          input string tag, input int poke);
        cur_tag = tag;
        @(negedge clk);
        start = 1; instr = ins; om = m; os = s; oa = a; ob = b;
        @(negedge clk);
        start = 0; instr = 32'hFFFF_FFFF;
        om = ~m; os = s ^ 32'h5A5A_5A5A; oa = ~a; ob = b + 32'd1;  // R11 disturb
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            start = 1; instr = mk(1, 1, 1, 1, 4'h9, 4'hA);
            om = 32'h1234_5678; os = 32'h8765_4321;
            @(negedge clk);
            start = 0;
        end
        wait_done(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !wa_en && !wb_en && !flag_we, "R10", "reset outputs",
            {busy, done, wa_en, wb_en, flag_we}, 5'b0);
        rst_n = 1;
        @(negedge clk);

        // R1 wrong pattern in bits 7:4
        cur_tag = "R1";
        start = 1; instr = mk(0, 0, 0, 0, 4'h1, 4'h2) ^ 32'h0000_0020;
        om = 5; os = 6;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1", "rejected start", {busy, done}, 2'b00);

        // R4 short multiply
        run_op(mk(0, 0, 0, 0, 4'h3, 4'h4), 32'd7, 32'd6, 32'h0, 32'h0, "R4", 0);
        run_op(mk(0, 1, 0, 0, 4'hF, 4'h0), 32'hFFFF_FFFF, 32'd2, 32'h0, 32'h0, "R4", 0);
        // R5 short accumulate, with wrap
        run_op(mk(0, 0, 1, 0, 4'h5, 4'h6), 32'd3, 32'd5, 32'hDEAD_0000, 32'd100, "R5", 0);
        run_op(mk(0, 1, 1, 0, 4'h5, 4'h6), 32'h8000_0000, 32'd3, 32'h0, 32'h8000_0001, "R5", 0);
        // R6 unsigned long
        run_op(mk(1, 0, 0, 0, 4'h7, 4'h8), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, "R6", 0);
        run_op(mk(1, 0, 0, 0, 4'h1, 4'h0), 32'h0001_0003, 32'h9000_0000, 32'h0, 32'h0, "R6", 0);
        // R7 signed long
        run_op(mk(1, 1, 0, 0, 4'h2, 4'h3), 32'hFFFF_FFFD, 32'd5, 32'h0, 32'h0, "R7", 0);
        run_op(mk(1, 1, 0, 0, 4'h2, 4'h3), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h0, "R7", 0);
        run_op(mk(1, 1, 0, 0, 4'h2, 4'h3), 32'h8000_0000, 32'h8000_0000, 32'h0, 32'h0, "R7", 0);
        run_op(mk(1, 1, 0, 0, 4'h2, 4'h3), 32'h7FFF_FFFF, 32'h8000_0000, 32'h0, 32'h0, "R7", 0);
        // R8 long accumulate, unsigned and signed, with carry into high word
        run_op(mk(1, 0, 1, 0, 4'hC, 4'hD), 32'hFFFF_FFFF, 32'h2, 32'h0000_0001, 32'hFFFF_FFFF, "R8", 0);
        run_op(mk(1, 1, 1, 0, 4'hC, 4'hD), 32'hFFFF_FFF0, 32'd3, 32'h0000_0000, 32'd10, "R8", 0);
        // R9 flags: zero, negative, long with zero low word
        run_op(mk(0, 0, 0, 1, 4'h1, 4'h2), 32'h0, 32'h1234, 32'h0, 32'h0, "R9", 0);
        run_op(mk(0, 0, 0, 1, 4'h1, 4'h2), 32'hFFFF_FFFF, 32'd1, 32'h0, 32'h0, "R9", 0);
        run_op(mk(1, 0, 0, 1, 4'h1, 4'h2), 32'h0001_0000, 32'h0001_0000, 32'h0, 32'h0, "R9", 0);
        run_op(mk(1, 1, 1, 1, 4'h1, 4'h2), 32'hFFFF_FFFF, 32'd1, 32'h0, 32'h0, "R9", 0);
        // R3 second start while busy
        run_op(mk(1, 0, 1, 1, 4'h4, 4'h5), 32'hABCD_1234, 32'h0F0F_F0F0, 32'h1, 32'h2, "R3", 5);
        run_op(mk(0, 0, 0, 0, 4'h4, 4'h5), 32'd9, 32'd9, 32'h0, 32'h0, "R3", 30);
        // R11 operand changes while busy
        run_op(mk(1, 1, 1, 0, 4'h6, 4'h7), 32'h1357_9BDF, 32'hFDB9_7531, 32'h0F00_0000, 32'h3, "R11", 0);

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule